// File: doc/BRIEF.md
# Global-History Direction Predictor with Speculative History Repair

This block predicts whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters indexed by the global branch history XORed with the low bits of the branch address, and predicts from the top bit of the selected counter. Each prediction returns the history value it used, so the pipeline can carry that snapshot to the branch's resolution.

The history used for prediction runs ahead of execution. Every prediction shifts its own predicted direction into a speculative history at once. A second, committed history advances only when branches resolve, using their real outcomes. When a resolution reports a misprediction, the speculative history is rebuilt from the committed history plus the actual outcome. The counters are trained only at resolution, at the index formed from the returned snapshot and the branch address, never at prediction time. Resolutions are expected in program order.

Top module: `gshare_spec_predictor`

## Requirements
- R1: After reset both histories are zero, the speculation flag is low, and every counter holds weakly taken (2'b10), so any address predicts taken.
- R2: The counter index is the speculative history XOR the low HIST_W bits of the prediction address, and the prediction is bit 1 of that counter (1 = taken).
- R3: `pred_hist` always shows the speculative history used for the prediction of the current cycle.
- R4: A prediction with no recovering resolution in the same cycle shifts the predicted direction into bit 0 of the speculative history at the next edge, dropping the oldest bit, and raises `spec_active`.
- R5: A resolution adds one to the counter on taken and subtracts one on not taken, stopping at 3 and at 0; predictions never change a counter.
- R6: A resolution trains the counter at `res_hist` XOR the low HIST_W bits of `res_addr`, not at the current history.
- R7: A resolution shifts its actual outcome into the committed history; with `res_mispred` high, the speculative history becomes that new committed history at the next edge and `spec_active` drops.
- R8: When a prediction and a recovering resolution share a cycle, the recovery wins and the prediction's direction is not shifted in.
- R9: A resolution without a misprediction, or an idle cycle, leaves the speculative history unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | A prediction is consumed this cycle |
| pred_addr | input | ADDR_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_hist | output | HIST_W | History snapshot used for this prediction |
| spec_active | output | 1 | Speculative history is ahead of the committed one |
| res_valid | input | 1 | A branch resolves this cycle |
| res_addr | input | ADDR_W | Address of the resolving branch |
| res_hist | input | HIST_W | Snapshot returned when that branch was predicted |
| res_taken | input | 1 | Actual outcome |
| res_mispred | input | 1 | The earlier prediction was wrong |

## Verification
The prediction and the resolution paths can act in the same cycle, and both write the speculative history and touch the counter table. The stimulus table drives a resolution together with a prediction once without a misprediction, where both histories advance and the counter read sees the value before training, and once with a misprediction, where the prediction's shift must be discarded. The outcome is judged from the next cycle's `pred_hist`, `spec_active` and `pred_taken` against hand-worked values.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX    = 2'b11;
  localparam ctr_t CTR_MIN    = 2'b00;
  localparam ctr_t CTR_WEAK_T = 2'b10;

  // Saturating counter step toward the observed direction.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    if (taken) return (cur == CTR_MAX) ? CTR_MAX : ctr_t'(cur + 2'd1);
    else       return (cur == CTR_MIN) ? CTR_MIN : ctr_t'(cur - 2'd1);
  endfunction

  // Direction encoded by a counter.
  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gsp_counter_table.sv
module gsp_counter_table
  import gsp_pkg::*;
#(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output ctr_t              rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken
);

  localparam int DEPTH = 1 << HIST_W;

  ctr_t ctr_q [DEPTH];
  ctr_t wr_old;
  ctr_t wr_new;

  assign rd_ctr = ctr_q[rd_idx];
  assign wr_old = ctr_q[wr_idx];
  assign wr_new = ctr_step(wr_old, wr_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WEAK_T;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_new;
    end
  end

  // R5: a taken resolution on a full counter leaves it full
  p_sat_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && wr_old == CTR_MAX |=> ctr_q[$past(wr_idx)] == CTR_MAX);

  // R5: a not-taken resolution on an empty counter leaves it empty
  p_sat_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_taken && wr_old == CTR_MIN |=> ctr_q[$past(wr_idx)] == CTR_MIN);

  // R5: a taken resolution below the top moves the counter up by one
  p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_taken && wr_old != CTR_MAX |=>
      ctr_q[$past(wr_idx)] == ctr_t'($past(wr_old) + 2'd1));

  // R5: with no resolution the counter that was read keeps its value
  p_no_spec_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ctr_q[$past(rd_idx)] == $past(rd_ctr));

endmodule

// File: rtl/gsp_history.sv
module gsp_history #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_pred,
  input  logic              pred_dir,
  input  logic              commit_en,
  input  logic              commit_dir,
  input  logic              recover,
  output logic [HIST_W-1:0] spec_hist,
  output logic              spec_active
);

  logic [HIST_W-1:0] commit_hist;
  logic [HIST_W-1:0] commit_next;
  logic [HIST_W-1:0] spec_shifted;

  assign commit_next  = {commit_hist[HIST_W-2:0], commit_dir};
  assign spec_shifted = {spec_hist[HIST_W-2:0], pred_dir};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_hist <= '0;
    end else if (commit_en) begin
      commit_hist <= commit_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spec_hist   <= '0;
      spec_active <= 1'b0;
    end else if (recover) begin
      spec_hist   <= commit_next;
      spec_active <= 1'b0;
    end else if (shift_pred) begin
      spec_hist   <= spec_shifted;
      spec_active <= 1'b1;
    end
  end

  // R4: a prediction moves its direction into the youngest history bit
  p_spec_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pred && !recover |=>
      spec_hist[0] == $past(pred_dir) && spec_active);

  // R7: after a recovery the two histories agree and speculation is off
  p_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    recover |=> spec_hist == commit_hist && !spec_active);

  // R9: without prediction or recovery the speculative history holds
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pred && !recover |=> $stable(spec_hist));

endmodule

// File: rtl/gshare_spec_predictor.sv
module gshare_spec_predictor
  import gsp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  input  logic [ADDR_W-1:0] pred_addr,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  output logic              spec_active,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic [HIST_W-1:0] res_hist,
  input  logic              res_taken,
  input  logic              res_mispred
);

  // Table index: history folded with the low address bits.
  function automatic logic [HIST_W-1:0] table_index(
    input logic [HIST_W-1:0] hist, input logic [ADDR_W-1:0] addr);
    return hist ^ addr[HIST_W-1:0];
  endfunction

  logic [HIST_W-1:0] spec_hist;
  logic [HIST_W-1:0] rd_idx;
  logic [HIST_W-1:0] wr_idx;
  ctr_t              rd_ctr;

  // Named internal events
  logic ev_recover;
  logic ev_shift;
  logic ev_commit;

  assign ev_commit  = res_valid;
  assign ev_recover = res_valid && res_mispred;
  assign ev_shift   = pred_valid && !ev_recover;

  assign rd_idx     = table_index(spec_hist, pred_addr);
  assign wr_idx     = table_index(res_hist, res_addr);
  assign pred_taken = ctr_dir(rd_ctr);
  assign pred_hist  = spec_hist;

  gsp_counter_table #(.HIST_W(HIST_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (ev_commit),
    .wr_idx   (wr_idx),
    .wr_taken (res_taken)
  );

  gsp_history #(.HIST_W(HIST_W)) u_hist (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_pred  (ev_shift),
    .pred_dir    (pred_taken),
    .commit_en   (ev_commit),
    .commit_dir  (res_taken),
    .recover     (ev_recover),
    .spec_hist   (spec_hist),
    .spec_active (spec_active)
  );

  // R8: a recovery in the same cycle as a prediction clears speculation
  p_recover_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && res_valid && res_mispred |=>
      !spec_active && spec_hist[0] == $past(res_taken));

  // R3: the reported snapshot tracks the shifted history
  p_snapshot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid && !res_valid |=>
      pred_hist[HIST_W-1:1] == $past(pred_hist[HIST_W-2:0]));

endmodule

// File: tb/gshare_spec_predictor_tb.sv
module gshare_spec_predictor_tb;

  localparam int ADDR_W = 16;
  localparam int HIST_W = 12;

  typedef struct packed {
    logic        pv;
    logic [15:0] paddr;
    logic        rv;
    logic [15:0] raddr;
    logic [15:0] rhist;
    logic        rt;
    logic        rm;
    logic        et;
    logic [15:0] eh;
    logic        ea;
  } vec_t;

  // Stimulus and outputs expected before the edge of each row.
  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{1'b1,16'h005,1'b0,16'h000,16'h000,1'b0,1'b0, 1'b1,16'h000,1'b0},
    '{1'b1,16'h005,1'b0,16'h000,16'h000,1'b0,1'b0, 1'b1,16'h001,1'b1},
    '{1'b0,16'h000,1'b1,16'h005,16'h000,1'b0,1'b1, 1'b1,16'h003,1'b1},
    '{1'b1,16'h005,1'b0,16'h000,16'h000,1'b0,1'b0, 1'b0,16'h000,1'b0},
    '{1'b1,16'h005,1'b1,16'h005,16'h000,1'b0,1'b0, 1'b0,16'h000,1'b1},
    '{1'b1,16'h005,1'b0,16'h000,16'h000,1'b0,1'b0, 1'b0,16'h000,1'b1},
    '{1'b1,16'h005,1'b1,16'h005,16'h000,1'b0,1'b0, 1'b0,16'h000,1'b1},
    '{1'b1,16'h005,1'b0,16'h000,16'h000,1'b0,1'b0, 1'b0,16'h000,1'b1},
    '{1'b1,16'h00A,1'b1,16'h00A,16'h000,1'b1,1'b1, 1'b1,16'h000,1'b1},
    '{1'b1,16'h00B,1'b0,16'h000,16'h000,1'b0,1'b0, 1'b1,16'h001,1'b0},
    '{1'b0,16'h000,1'b1,16'h00B,16'h001,1'b1,1'b0, 1'b1,16'h003,1'b1},
    '{1'b1,16'h009,1'b0,16'h000,16'h000,1'b0,1'b0, 1'b1,16'h003,1'b1},
    '{1'b0,16'h007,1'b0,16'h000,16'h000,1'b0,1'b0, 1'b1,16'h007,1'b1},
    '{1'b0,16'h007,1'b1,16'h007,16'h003,1'b0,1'b1, 1'b1,16'h007,1'b1},
    '{1'b1,16'h002,1'b0,16'h000,16'h000,1'b0,1'b0, 1'b0,16'h006,1'b0},
    '{1'b0,16'h000,1'b0,16'h000,16'h000,1'b0,1'b0, 1'b1,16'h00C,1'b1}
  };

  localparam string VREQ [NV] = '{
    "R1 R2",            // weakly-taken counter at 0x005
    "R3 R4",            // history shifted by the first prediction
    "R7",               // mispredict recovery, output before the edge
    "R5 R7",            // counter trained down, history repaired to zero
    "R5 R8",            // resolve + predict together, read sees old counter
    "R5",               // counter now at 0
    "R5",               // not-taken on empty counter
    "R5",               // still 0: saturation at the bottom
    "R8",               // recovery beats the same-cycle prediction
    "R7 R5",            // history = 1 after recovery, counter at 3
    "R9",               // correct resolve leaves speculative history
    "R5 R6",            // taken on full counter stays full
    "R2 R9",            // idle cycle, history held
    "R7",               // mispredict with a non-zero committed history
    "R6 R7",            // trained counter found via the snapshot index
    "R4"                // shift after recovery
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pred_valid;
  logic [ADDR_W-1:0] pred_addr;
  logic              pred_taken;
  logic [HIST_W-1:0] pred_hist;
  logic              spec_active;
  logic              res_valid;
  logic [ADDR_W-1:0] res_addr;
  logic [HIST_W-1:0] res_hist;
  logic              res_taken;
  logic              res_mispred;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  gshare_spec_predictor #(.ADDR_W(ADDR_W), .HIST_W(HIST_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pred_valid  (pred_valid),
    .pred_addr   (pred_addr),
    .pred_taken  (pred_taken),
    .pred_hist   (pred_hist),
    .spec_active (spec_active),
    .res_valid   (res_valid),
    .res_addr    (res_addr),
    .res_hist    (res_hist),
    .res_taken   (res_taken),
    .res_mispred (res_mispred)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    pred_valid  = 1'b0;
    pred_addr   = '0;
    res_valid   = 1'b0;
    res_addr    = '0;
    res_hist    = '0;
    res_taken   = 1'b0;
    res_mispred = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    do_reset();

    // R1: reset state seen at the ports
    #1;
    check("R1", "hist after reset", 16'(pred_hist), 16'h000);
    check("R1", "flag after reset", 16'(spec_active), 16'h0);

    // Table walk: inputs at the falling edge, outputs checked 1 ns later
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pred_valid  = VT[i].pv;
      pred_addr   = VT[i].paddr;
      res_valid   = VT[i].rv;
      res_addr    = VT[i].raddr;
      res_hist    = VT[i].rhist[HIST_W-1:0];
      res_taken   = VT[i].rt;
      res_mispred = VT[i].rm;
      #1;
      check(VREQ[i], $sformatf("row %0d taken", i), 16'(pred_taken), 16'(VT[i].et));
      check(VREQ[i], $sformatf("row %0d hist", i),  16'(pred_hist),  VT[i].eh);
      check(VREQ[i], $sformatf("row %0d flag", i),  16'(spec_active), 16'(VT[i].ea));
    end

    // R1: reset mid-run restores weakly-taken counters (0x005 was at 0)
    do_reset();
    pred_addr = 16'h005;
    #1;
    check("R1", "ctr 0x005 after reset", 16'(pred_taken), 16'h1);
    pred_addr = 16'h00A;
    #1;
    check("R1", "ctr 0x00A after reset", 16'(pred_taken), 16'h1);
    check("R1", "hist after 2nd reset", 16'(pred_hist), 16'h000);

    // R4: thirteen taken predictions fill the history and drop the oldest bit
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      pred_valid = 1'b1;
      pred_addr  = 16'h800;
    end
    @(negedge clk);
    idle_inputs();
    #1;
    check("R4", "history full of taken", 16'(pred_hist), 16'h0FFF);
    check("R4", "flag after shifts", 16'(spec_active), 16'h1);

    // R9: a correct resolution does not touch the speculative history
    @(negedge clk);
    res_valid = 1'b1;
    res_addr  = 16'h123;
    res_taken = 1'b1;
    @(negedge clk);
    idle_inputs();
    #1;
    check("R9", "hist after correct resolve", 16'(pred_hist), 16'h0FFF);

    // R7: recovery rebuilds from committed history (0b1) plus outcome 0
    @(negedge clk);
    res_valid   = 1'b1;
    res_addr    = 16'h123;
    res_taken   = 1'b0;
    res_mispred = 1'b1;
    @(negedge clk);
    idle_inputs();
    #1;
    check("R7", "hist after recovery", 16'(pred_hist), 16'h002);
    check("R7", "flag after recovery", 16'(spec_active), 16'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule